// File: doc/BRIEF.md
# Programmable Interval Timer with Reload

The block is a bus-mapped interval timer built around a synchronous binary counter. Software loads an interval into a write-only holding register, picks a count rate, a count direction and a rollover policy in a control/status register, and then sets the run bit. On each cycle where the timer runs and the selected rate strobe is high, the counter moves by one. When it wraps, either below zero or above its maximum, the timer raises a sticky done flag. That flag drives an interrupt request when interrupts are enabled. With interrupts left disabled the timer works as a polled, non-interrupt timer.

The two rollover policies differ. In single-shot policy, a wrap clears both the counter and the holding register and stops the timer. In repeating policy, a wrap reloads the counter from the holding register and the timer keeps running. The fourth rate source is an asynchronous external input. It passes through a synchronizer and a rising-edge detector, so with upward counting the timer becomes an external event counter. The three other sources arrive as single-cycle enable strobes.

The control sequencer has two states, STOPPED and RUNNING. The START transition (STOPPED to RUNNING) happens on a control write with run=1 and copies the holding register into the counter. The HALT transition (RUNNING to STOPPED) happens on a control write with run=0. The SHOT transition (RUNNING to STOPPED) happens on a wrap in single-shot policy. RELOAD is the wrap in repeating policy and stays in RUNNING. A synchronous init input forces STOPPED from either state.

Top module: `interval_timer`

## Requirements
- R1: After reset, every register reads zero and irq is low. The register map is: address 0 is control/status, address 1 is the holding register, address 2 is the live counter (zero-extended). Control bits are run=bit0, rate select=bits 2:1 (0 fast strobe, 1 slow strobe, 2 line strobe, 3 external input), policy=bit3 (0 single-shot, 1 repeating), direction=bit4 (1 up, 0 down), interrupt enable=bit6, done=bit7.
- R2: The holding register always reads zero at address 1. Writing it does not change the counter. A control write with run=1 while the timer is stopped copies it into the counter.
- R3: The counter changes only in a cycle where the timer runs and the selected rate strobe is high. Unselected strobes have no effect, and neither do strobes while the timer is stopped.
- R4: When counting down, each counted strobe decrements the counter. A counted strobe at zero is an underflow (a wrap).
- R5: When counting up, each counted strobe increments the counter. A counted strobe at the all-ones value is an overflow (a wrap).
- R6: In single-shot policy, a wrap sets the counter and the holding register to zero, clears run and sets done.
- R7: In repeating policy, a wrap reloads the counter from the holding register, leaves run set and sets done.
- R8: Done stays set until any control write clears it, and irq equals done AND interrupt enable.
- R9: With rate select 3, the counter counts once per rising edge of ext_in, seen after a two-flop synchronizer. A level held high and a falling edge do not count.
- R10: A control write with run=1 while the timer is running leaves the counter unchanged.
- R11: A one-cycle init clears the counter, the holding register and all control/status bits, and stops the timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init | input | 1 | Synchronous system init |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | BUS_W | Write data |
| bus_rdata | output | BUS_W | Read data for bus_addr (combinational) |
| tick_fast | input | 1 | Fast crystal-rate strobe |
| tick_slow | input | 1 | Slow crystal-rate strobe |
| tick_line | input | 1 | Line-frequency strobe |
| ext_in | input | 1 | Asynchronous external count input |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the timer with a 4-bit counter (CNT_W=4) and the default 16-bit bus. With only sixteen counter values, every starting interval can be swept in both directions and both rollover policies. Each underflow and overflow is then reached within a few ticks, and every count value is compared against arithmetic in the bench. Repeating policy is run through several full periods per interval. This exposes reload and done-flag errors that only show up on the second wrap.

// File: rtl/timer_pkg.sv
package timer_pkg;

    typedef enum logic [0:0] {
        ST_STOPPED = 1'b0,
        ST_RUNNING = 1'b1
    } tmr_state_e;

    typedef enum logic [1:0] {
        RATE_FAST = 2'd0,
        RATE_SLOW = 2'd1,
        RATE_LINE = 2'd2,
        RATE_EXT  = 2'd3
    } rate_sel_e;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_HOLD = 2'd1;
    localparam logic [1:0] ADDR_CNT  = 2'd2;

    localparam int CTL_RUN  = 0;
    localparam int CTL_SEL  = 1;
    localparam int CTL_POL  = 3;
    localparam int CTL_UP   = 4;
    localparam int CTL_IE   = 6;
    localparam int CTL_DONE = 7;

endpackage

// File: rtl/timer_sync_edge.sv
module timer_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic rise
);
    localparam int LAST = STAGES;

    // chain[0..STAGES-1] synchronize, chain[LAST] holds the previous level
    logic [LAST:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[LAST-1:0], d_async};
    end

    assign rise = chain[LAST-1] & ~chain[LAST];
endmodule

// File: rtl/timer_rate_mux.sv
module timer_rate_mux
    import timer_pkg::*;
(
    input  rate_sel_e sel,
    input  logic      tick_fast,
    input  logic      tick_slow,
    input  logic      tick_line,
    input  logic      ext_rise,
    output logic      tick
);
    always_comb begin
        unique case (sel)
            RATE_FAST: tick = tick_fast;
            RATE_SLOW: tick = tick_slow;
            RATE_LINE: tick = tick_line;
            RATE_EXT:  tick = ext_rise;
        endcase
    end
endmodule

// File: rtl/timer_core.sv
module timer_core
    import timer_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             init,
    input  logic             start_req,
    input  logic             halt_req,
    input  logic             hold_we,
    input  logic [CNT_W-1:0] hold_wdata,
    input  logic             repeat_pol,
    input  logic             dir_up,
    input  logic             tick,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] hold_q,
    output logic             running,
    output logic             wrap_evt
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    tmr_state_e state_q, state_d;
    logic       at_limit;
    logic       step;

    assign at_limit = dir_up ? (cnt_q == CNT_MAX) : (cnt_q == '0);
    assign step     = (state_q == ST_RUNNING) && !halt_req && tick;
    assign wrap_evt = step && at_limit;
    assign running  = (state_q == ST_RUNNING);

    // Next-state: START, HALT, SHOT; RELOAD stays in RUNNING
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_STOPPED: if (start_req) state_d = ST_RUNNING;
            ST_RUNNING: begin
                if (halt_req)                     state_d = ST_STOPPED;
                else if (wrap_evt && !repeat_pol) state_d = ST_STOPPED;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    state_q <= ST_STOPPED;
        else if (init) state_q <= ST_STOPPED;
        else           state_q <= state_d;
    end

    // Datapath outputs of the sequencer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            hold_q <= '0;
        end else if (init) begin
            cnt_q  <= '0;
            hold_q <= '0;
        end else begin
            if ((state_q == ST_STOPPED) && start_req) begin
                cnt_q <= hold_q;
            end else if (step) begin
                if (at_limit)    cnt_q <= repeat_pol ? hold_q : '0;
                else if (dir_up) cnt_q <= cnt_q + CNT_ONE;
                else             cnt_q <= cnt_q - CNT_ONE;
            end
            if (hold_we)                      hold_q <= hold_wdata;
            else if (wrap_evt && !repeat_pol) hold_q <= '0;
        end
    end
endmodule

// File: rtl/interval_timer.sv
module interval_timer
    import timer_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int BUS_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             init,
    input  logic [1:0]       bus_addr,
    input  logic             bus_wr,
    input  logic [BUS_W-1:0] bus_wdata,
    output logic [BUS_W-1:0] bus_rdata,
    input  logic             tick_fast,
    input  logic             tick_slow,
    input  logic             tick_line,
    input  logic             ext_in,
    output logic             irq
);
    rate_sel_e        sel_q;
    logic             mode_q, up_q, ie_q, done_q;
    logic             ctrl_we, hold_we, start_req, halt_req;
    logic             ext_rise, tick_sel;
    logic [CNT_W-1:0] cnt_q, hold_q;
    logic             running, wrap_evt;

    assign ctrl_we   = bus_wr && (bus_addr == ADDR_CTRL);
    assign hold_we   = bus_wr && (bus_addr == ADDR_HOLD);
    assign start_req = ctrl_we &&  bus_wdata[CTL_RUN];
    assign halt_req  = ctrl_we && !bus_wdata[CTL_RUN];

    timer_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (ext_in),
        .rise    (ext_rise)
    );

    timer_rate_mux u_mux (
        .sel       (sel_q),
        .tick_fast (tick_fast),
        .tick_slow (tick_slow),
        .tick_line (tick_line),
        .ext_rise  (ext_rise),
        .tick      (tick_sel)
    );

    timer_core #(.CNT_W(CNT_W)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .init       (init),
        .start_req  (start_req),
        .halt_req   (halt_req),
        .hold_we    (hold_we),
        .hold_wdata (bus_wdata[CNT_W-1:0]),
        .repeat_pol (mode_q),
        .dir_up     (up_q),
        .tick       (tick_sel),
        .cnt_q      (cnt_q),
        .hold_q     (hold_q),
        .running    (running),
        .wrap_evt   (wrap_evt)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q  <= RATE_FAST;
            mode_q <= 1'b0;
            up_q   <= 1'b0;
            ie_q   <= 1'b0;
            done_q <= 1'b0;
        end else if (init) begin
            sel_q  <= RATE_FAST;
            mode_q <= 1'b0;
            up_q   <= 1'b0;
            ie_q   <= 1'b0;
            done_q <= 1'b0;
        end else begin
            if (ctrl_we) begin
                sel_q  <= rate_sel_e'(bus_wdata[CTL_SEL +: 2]);
                mode_q <= bus_wdata[CTL_POL];
                up_q   <= bus_wdata[CTL_UP];
                ie_q   <= bus_wdata[CTL_IE];
            end
            if (wrap_evt)     done_q <= 1'b1;
            else if (ctrl_we) done_q <= 1'b0;
        end
    end

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            ADDR_CTRL: begin
                bus_rdata[CTL_RUN]        = running;
                bus_rdata[CTL_SEL +: 2]   = sel_q;
                bus_rdata[CTL_POL]        = mode_q;
                bus_rdata[CTL_UP]         = up_q;
                bus_rdata[CTL_IE]         = ie_q;
                bus_rdata[CTL_DONE]       = done_q;
            end
            ADDR_CNT: bus_rdata[CNT_W-1:0] = cnt_q;
            default: ;
        endcase
    end

    assign irq = done_q & ie_q;
endmodule

// File: rtl/timer_chk.sv
module timer_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             init,
    input logic             ctrl_we,
    input logic             hold_we,
    input logic             start_req,
    input logic             tick_sel,
    input logic             running,
    input logic             up_q,
    input logic             mode_q,
    input logic             done_q,
    input logic             wrap_evt,
    input logic [CNT_W-1:0] cnt_q,
    input logic [CNT_W-1:0] hold_q
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    // R3
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_sel && !start_req && !init) |=> $stable(cnt_q));

    // R4
    down_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (running && tick_sel && !up_q && cnt_q != '0 && !ctrl_we && !init)
        |=> cnt_q == $past(cnt_q) - ONE);

    // R5
    up_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (running && tick_sel && up_q && cnt_q != {CNT_W{1'b1}} && !ctrl_we && !init)
        |=> cnt_q == $past(cnt_q) + ONE);

    // R6
    single_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap_evt && !mode_q && !hold_we && !init)
        |=> (cnt_q == '0) && (hold_q == '0) && !running && done_q);

    // R7
    reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap_evt && mode_q && !init)
        |=> (cnt_q == $past(hold_q)) && running && done_q);

    // R8
    done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q && !ctrl_we && !init) |=> done_q);

    // R11
    init_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        init |=> (cnt_q == '0) && (hold_q == '0) && !running && !done_q);
endmodule

bind interval_timer timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .init      (init),
    .ctrl_we   (ctrl_we),
    .hold_we   (hold_we),
    .start_req (start_req),
    .tick_sel  (tick_sel),
    .running   (running),
    .up_q      (up_q),
    .mode_q    (mode_q),
    .done_q    (done_q),
    .wrap_evt  (wrap_evt),
    .cnt_q     (cnt_q),
    .hold_q    (hold_q)
);

// File: tb/tb_interval_timer.sv
module tb_interval_timer;
    localparam int CW    = 4;
    localparam int BW    = 16;
    localparam int TOP_V = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          init = 1'b0;
    logic [1:0]    bus_addr = 2'd0;
    logic          bus_wr = 1'b0;
    logic [BW-1:0] bus_wdata = '0;
    logic [BW-1:0] bus_rdata;
    logic          tick_fast = 1'b0, tick_slow = 1'b0, tick_line = 1'b0;
    logic          ext_in = 1'b0;
    logic          irq;

    int checks = 0;
    int errors = 0;
    bit done_run = 1'b0;

    interval_timer #(.CNT_W(CW), .BUS_W(BW), .SYNC_STAGES(2)) dut (
        .clk, .rst_n, .init, .bus_addr, .bus_wr, .bus_wdata, .bus_rdata,
        .tick_fast, .tick_slow, .tick_line, .ext_in, .irq
    );

    always #10 clk = ~clk;

    function automatic logic [15:0] ctl(bit run, logic [1:0] sel, bit pol,
                                        bit up, bit ie, bit dn);
        return 16'(run) | (16'(sel) << 1) | (16'(pol) << 3) |
               (16'(up) << 4) | (16'(ie) << 6) | (16'(dn) << 7);
    endfunction

    task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] a, logic [15:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [1:0] a, output logic [15:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic pulse(int which);
        case (which)
            0: tick_fast = 1'b1;
            1: tick_slow = 1'b1;
            default: tick_line = 1'b1;
        endcase
        @(negedge clk);
        tick_fast = 1'b0; tick_slow = 1'b0; tick_line = 1'b0;
    endtask

    task automatic do_init();
        init = 1'b1;
        @(negedge clk);
        init = 1'b0;
    endtask

    task automatic ext_pulse();
        ext_in = 1'b1;
        repeat (4) @(negedge clk);
        ext_in = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done_run) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(2'd0, v); chk("R1 ctrl", v, 16'h0);
        rd(2'd1, v); chk("R1 hold", v, 16'h0);
        rd(2'd2, v); chk("R1 count", v, 16'h0);
        chk("R1 irq", 16'(irq), 16'h0);

        // R2 hold reads zero, start loads it
        wr(2'd1, 16'd9);
        rd(2'd1, v); chk("R2 hold read", v, 16'h0);
        rd(2'd2, v); chk("R2 write no load", v, 16'h0);

        // R3 rate selection and stop
        wr(2'd1, 16'd5);
        wr(2'd0, ctl(1, 2'd1, 0, 0, 0, 0));
        rd(2'd2, v); chk("R2 start load", v, 16'd5);
        pulse(0); pulse(2);
        rd(2'd2, v); chk("R3 unselected", v, 16'd5);
        pulse(1);
        rd(2'd2, v); chk("R3 selected", v, 16'd4);
        wr(2'd1, 16'd12);
        rd(2'd2, v); chk("R2 hold write running", v, 16'd4);
        wr(2'd0, ctl(1, 2'd1, 0, 0, 0, 0));
        rd(2'd2, v); chk("R10 rewrite run", v, 16'd4);
        wr(2'd0, ctl(0, 2'd1, 0, 0, 0, 0));
        pulse(1);
        rd(2'd2, v); chk("R3 stopped", v, 16'd4);

        // R4 R6 single-shot down sweep
        for (int n = 0; n <= TOP_V; n++) begin
            do_init();
            wr(2'd1, 16'(n));
            wr(2'd0, ctl(1, 2'd0, 0, 0, 1, 0));
            for (int k = 1; k <= n; k++) begin
                pulse(0);
                rd(2'd2, v); chk("R4 down step", v, 16'(n - k));
            end
            rd(2'd0, v); chk("R8 no done early", v, ctl(1, 2'd0, 0, 0, 1, 0));
            pulse(0);
            rd(2'd2, v); chk("R6 count cleared", v, 16'h0);
            rd(2'd0, v); chk("R6 stop and done", v, ctl(0, 2'd0, 0, 0, 1, 1));
            chk("R8 irq set", 16'(irq), 16'h1);
            wr(2'd0, ctl(1, 2'd0, 0, 0, 1, 0));
            rd(2'd2, v); chk("R6 hold cleared", v, 16'h0);
            chk("R8 irq cleared", 16'(irq), 16'h0);
            wr(2'd0, 16'h0);
        end

        // R5 R6 single-shot up sweep
        for (int n = 0; n <= TOP_V; n++) begin
            do_init();
            wr(2'd1, 16'(n));
            wr(2'd0, ctl(1, 2'd2, 0, 1, 0, 0));
            for (int k = n; k < TOP_V; k++) pulse(2);
            rd(2'd2, v); chk("R5 up to max", v, 16'(TOP_V));
            pulse(2);
            rd(2'd2, v); chk("R5 overflow clear", v, 16'h0);
            rd(2'd0, v); chk("R6 up stop done", v, ctl(0, 2'd2, 0, 1, 0, 1));
            chk("R8 irq masked", 16'(irq), 16'h0);
        end

        // R7 repeating down sweep
        for (int n = 0; n <= TOP_V; n++) begin
            do_init();
            wr(2'd1, 16'(n));
            wr(2'd0, ctl(1, 2'd0, 1, 0, 0, 0));
            for (int p = 0; p < 3; p++) begin
                for (int k = 0; k < n; k++) pulse(0);
                rd(2'd2, v); chk("R4 reach zero", v, 16'h0);
                pulse(0);
                rd(2'd2, v); chk("R7 reload down", v, 16'(n));
                rd(2'd0, v); chk("R7 still running", v, ctl(1, 2'd0, 1, 0, 0, 1));
                wr(2'd0, ctl(1, 2'd0, 1, 0, 0, 0));
                rd(2'd0, v); chk("R8 write clears", v, ctl(1, 2'd0, 1, 0, 0, 0));
                rd(2'd2, v); chk("R10 no reload", v, 16'(n));
            end
        end

        // R7 repeating up sweep
        for (int n = 0; n <= TOP_V; n++) begin
            do_init();
            wr(2'd1, 16'(n));
            wr(2'd0, ctl(1, 2'd0, 1, 1, 1, 0));
            for (int p = 0; p < 2; p++) begin
                for (int k = n; k < TOP_V; k++) pulse(0);
                pulse(0);
                rd(2'd2, v); chk("R7 reload up", v, 16'(n));
                chk("R8 irq repeat", 16'(irq), 16'h1);
            end
        end

        // R9 external event counting
        do_init();
        wr(2'd1, 16'd2);
        wr(2'd0, ctl(1, 2'd3, 0, 1, 0, 0));
        pulse(0);
        rd(2'd2, v); chk("R9 strobe ignored", v, 16'd2);
        for (int k = 1; k <= 3; k++) begin
            ext_pulse();
            rd(2'd2, v); chk("R9 edge count", v, 16'(2 + k));
        end
        ext_in = 1'b1;
        repeat (10) @(negedge clk);
        rd(2'd2, v); chk("R9 level once", v, 16'd6);
        ext_in = 1'b0;
        repeat (4) @(negedge clk);
        rd(2'd2, v); chk("R9 fall ignored", v, 16'd6);

        // R11 init while running
        do_init();
        wr(2'd1, 16'd7);
        wr(2'd0, ctl(1, 2'd0, 1, 0, 1, 0));
        pulse(0); pulse(0);
        rd(2'd2, v); chk("R11 pre", v, 16'd5);
        do_init();
        rd(2'd2, v); chk("R11 count", v, 16'h0);
        rd(2'd0, v); chk("R11 ctrl", v, 16'h0);
        pulse(0);
        rd(2'd2, v); chk("R11 stopped", v, 16'h0);
        wr(2'd0, ctl(1, 2'd0, 0, 0, 0, 0));
        rd(2'd2, v); chk("R11 hold", v, 16'h0);

        done_run = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule